// File: doc/BRIEF.md
# Acknowledge-Driven Retransmit Label Queue

This block serves one input channel of a time-slotted packet switch. Packet labels from the channel's traffic source are held in a bounded first-in first-out store. In every slot the label at the front of the store is offered to the switch controller. In the same slot, the gate enable for the channel's payload gate is raised. The front entry is released only when the controller returns a positive acknowledge during that slot. A slot that ends without an acknowledge leaves the front entry in place, so the same label and gate are offered again in the next slot. This is how a lost contention is retried.

One clock cycle is one slot. A label that arrives when every entry is occupied is discarded, unless the front entry is acknowledged in that same slot. Discarded labels and retransmitted offers are tallied in saturating counters. The current fill level is presented as an occupancy output.

Top module: `retx_label_queue`

## Requirements
- R1: After a synchronous reset, occupancy, tx_valid, gate, drop_count and retx_count are all zero.
- R2: While the queue holds no label, tx_valid and gate stay low.
- R3: occupancy equals the number of stored labels, is updated one cycle after the arrival or release that changes it, and never exceeds DEPTH.
- R4: Labels are offered on tx_label in the order in which they were accepted.
- R5: gate is high in exactly the cycles in which tx_valid is high.
- R6: ack high in a cycle with tx_valid high releases the front label, and the next stored label (if any) is offered in the following cycle.
- R7: A cycle with tx_valid high and ack low offers the same label again in the following cycle and raises retx_count by one.
- R8: An arrival in a cycle where occupancy equals DEPTH and no release happens is discarded: stored labels are unchanged and drop_count rises by one.
- R9: An arrival in a cycle where occupancy equals DEPTH and the front label is released is accepted, and occupancy stays at DEPTH.
- R10: drop_count and retx_count stop at 2^CNT_W-1 and do not wrap.
- R11: ack while tx_valid is low has no effect on occupancy, the stored labels or retx_count.
- R12: A label that arrives while the queue is empty is offered on tx_label in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one cycle per slot |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A new label arrives this slot |
| in_label | input | LABEL_W | Arriving label |
| ack | input | 1 | Positive acknowledge for the label offered this slot |
| tx_valid | output | 1 | A label is offered this slot |
| tx_label | output | LABEL_W | Offered label (front of queue) |
| gate | output | 1 | Payload gate enable for this channel |
| occupancy | output | $clog2(DEPTH+1) | Number of stored labels |
| drop_count | output | CNT_W | Saturating count of discarded arrivals |
| retx_count | output | CNT_W | Saturating count of unacknowledged offers |

## Verification
A corrupted read or write pointer appears at tx_label in the next slot as an out-of-order or stale label. A wrong fill count appears at occupancy one cycle after the event that caused it. Either error also shows as a wrong full decision, which moves drop_count away from the model within a few slots of saturation. Because the reference queue is compared with every output on every cycle, any such divergence is reported in the cycle it first becomes visible. Directed slots cover the cases where the queue is full: an arrival with a release in the same slot, an arrival without one, and a counter pinned at its ceiling.

// File: rtl/rlq_pkg.sv
package rlq_pkg;
  typedef struct packed {
    logic push;
    logic pop;
    logic drop;
    logic resend;
  } slot_evt_t;
endpackage

// File: rtl/rlq_label_ram.sv
module rlq_label_ram #(
  parameter int W     = 2,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/rlq_sat_counter.sv
module rlq_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else if (inc && count != TOP) count <= count + 1'b1;
  end

  assert_sat_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (count == TOP) |=> (count == TOP));
endmodule

// File: rtl/retx_label_queue.sv
module retx_label_queue
  import rlq_pkg::*;
#(
  parameter int LABEL_W = 2,
  parameter int DEPTH   = 8,
  parameter int CNT_W   = 16,
  localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int OW     = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [LABEL_W-1:0] in_label,
  input  logic               ack,
  output logic               tx_valid,
  output logic [LABEL_W-1:0] tx_label,
  output logic               gate,
  output logic [OW-1:0]      occupancy,
  output logic [CNT_W-1:0]   drop_count,
  output logic [CNT_W-1:0]   retx_count
);
  localparam logic [OW-1:0] FULL_LVL = OW'(DEPTH);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  logic [AW-1:0]      rd_ptr, wr_ptr, rd_next;
  logic [OW-1:0]      count_q, count_next;
  logic               valid_q, byp_q;
  logic [LABEL_W-1:0] byp_label_q, ram_q;
  slot_evt_t          evt;

  always_comb begin
    evt.pop    = valid_q & ack;
    evt.resend = valid_q & ~ack;
    evt.push   = in_valid & ((count_q != FULL_LVL) | evt.pop);
    evt.drop   = in_valid & (count_q == FULL_LVL) & ~evt.pop;
    rd_next    = evt.pop ? wrap_inc(rd_ptr) : rd_ptr;
    count_next = count_q + OW'(evt.push) - OW'(evt.pop);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr      <= '0;
      wr_ptr      <= '0;
      count_q     <= '0;
      valid_q     <= 1'b0;
      byp_q       <= 1'b0;
      byp_label_q <= '0;
    end else begin
      rd_ptr      <= rd_next;
      count_q     <= count_next;
      valid_q     <= (count_next != '0);
      byp_q       <= evt.push && (wr_ptr == rd_next);
      byp_label_q <= in_label;
      if (evt.push) wr_ptr <= wrap_inc(wr_ptr);
    end
  end

  rlq_label_ram #(.W(LABEL_W), .DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .we    (evt.push),
    .waddr (wr_ptr),
    .wdata (in_label),
    .raddr (rd_next),
    .rdata (ram_q)
  );

  rlq_sat_counter #(.W(CNT_W)) u_drop_cnt (
    .clk (clk), .rst (rst), .inc (evt.drop), .count (drop_count)
  );

  rlq_sat_counter #(.W(CNT_W)) u_retx_cnt (
    .clk (clk), .rst (rst), .inc (evt.resend), .count (retx_count)
  );

  assign tx_valid  = valid_q;
  assign gate      = valid_q;
  assign tx_label  = byp_q ? byp_label_q : ram_q;
  assign occupancy = count_q;

  // Assertions guarding the queue state
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    occupancy <= FULL_LVL);

  assert_empty_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (occupancy == '0) |-> (!tx_valid && !gate));

  assert_gate_follows_R5: assert property (@(posedge clk) disable iff (rst)
    gate == tx_valid);

  assert_resend_same_R7: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !ack) |=> (tx_valid && $stable(tx_label)));

  assert_full_drop_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && occupancy == FULL_LVL && !ack) |=> (occupancy == FULL_LVL));

  assert_full_swap_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && occupancy == FULL_LVL && ack) |=>
      (occupancy == FULL_LVL && $stable(drop_count)));

  assert_idle_ack_R11: assert property (@(posedge clk) disable iff (rst)
    (!tx_valid && !in_valid) |=> (occupancy == '0 && $stable(retx_count)));
endmodule

// File: tb/tb_retx_label_queue.sv
module tb_retx_label_queue;
  localparam int LW    = 2;
  localparam int DEPTH = 8;
  localparam int CW    = 4;
  localparam int OW    = $clog2(DEPTH + 1);
  localparam int CMAX  = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [LW-1:0] in_label = '0;
  logic          ack = 1'b0;
  logic          tx_valid, gate;
  logic [LW-1:0] tx_label;
  logic [OW-1:0] occupancy;
  logic [CW-1:0] drop_count, retx_count;

  int errors = 0;
  int checks = 0;

  // model state
  int mq[$];
  int m_drop = 0;
  int m_retx = 0;

  always #2 clk = ~clk;

  retx_label_queue #(.LABEL_W(LW), .DEPTH(DEPTH), .CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_label(in_label), .ack(ack),
    .tx_valid(tx_valid), .tx_label(tx_label), .gate(gate),
    .occupancy(occupancy), .drop_count(drop_count), .retx_count(retx_count)
  );

  always @(posedge clk) begin
    if (rst) begin
      mq.delete();
      m_drop = 0;
      m_retx = 0;
    end else begin
      bit rel;
      rel = (mq.size() > 0) && ack;
      if (mq.size() > 0 && !ack && m_retx < CMAX) m_retx++;
      if (rel) void'(mq.pop_front());
      if (in_valid) begin
        if (mq.size() < DEPTH) mq.push_back(int'(in_label));
        else if (m_drop < CMAX) m_drop++;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R3 occupancy", int'(occupancy), mq.size());
    chk("R2/R6 tx_valid", int'(tx_valid), int'(mq.size() > 0));
    chk("R5 gate", int'(gate), int'(mq.size() > 0));
    if (mq.size() > 0) chk("R4/R7 tx_label", int'(tx_label), mq[0]);
    chk("R8 drop_count", int'(drop_count), m_drop);
    chk("R7 retx_count", int'(retx_count), m_retx);
  endtask

  task automatic slot(input bit v, input int l, input bit a);
    in_valid = v;
    in_label = LW'(l);
    ack      = a;
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 occupancy", int'(occupancy), 0);
    chk("R1 tx_valid", int'(tx_valid), 0);
    chk("R1 gate", int'(gate), 0);
    chk("R1 drop_count", int'(drop_count), 0);
    chk("R1 retx_count", int'(retx_count), 0);

    // R11: ack with nothing offered
    slot(0, 0, 1);
    slot(0, 0, 1);
    chk("R11 occupancy", int'(occupancy), 0);
    chk("R11 retx_count", int'(retx_count), 0);

    // R12: arrival into empty queue offered next cycle
    slot(1, 2, 0);
    chk("R12 tx_valid", int'(tx_valid), 1);
    chk("R12 tx_label", int'(tx_label), 2);
    // R6: release, queue becomes empty
    slot(0, 0, 1);
    chk("R6 tx_valid", int'(tx_valid), 0);

    // fill to DEPTH with no acks: labels 1,2,3,0,...
    for (int i = 0; i < DEPTH; i++) slot(1, (i + 1) % 4, 0);
    chk("R3 full occupancy", int'(occupancy), DEPTH);
    chk("R4 head label", int'(tx_label), 1);
    // R8: arrival while full without release
    slot(1, 3, 0);
    chk("R8 drop_count", int'(drop_count), 1);
    chk("R8 occupancy", int'(occupancy), DEPTH);
    chk("R8 head unchanged", int'(tx_label), 1);
    // R9: arrival while full with release
    slot(1, 0, 1);
    chk("R9 occupancy", int'(occupancy), DEPTH);
    chk("R9 drop_count", int'(drop_count), 1);
    chk("R9 next head", int'(tx_label), 2);
    // R10: hold without ack well past the ceiling
    for (int i = 0; i < 20; i++) slot(0, 0, 0);
    chk("R10 retx_count saturated", int'(retx_count), CMAX);
    for (int i = 0; i < 20; i++) slot(1, i, 0);
    chk("R10 drop_count saturated", int'(drop_count), CMAX);
    // drain in order
    for (int i = 0; i < DEPTH; i++) slot(0, 0, 1);
    chk("R2 drained tx_valid", int'(tx_valid), 0);
    chk("R2 drained gate", int'(gate), 0);

    // random phases: heavy load, light load, balanced
    for (int ph = 0; ph < 3; ph++) begin
      int pin, pack;
      pin  = (ph == 0) ? 90 : (ph == 1) ? 20 : 50;
      pack = (ph == 0) ? 30 : (ph == 1) ? 80 : 50;
      for (int i = 0; i < 400; i++)
        slot(($urandom % 100) < pin, int'($urandom % 4), ($urandom % 100) < pack);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule